// File: doc/BRIEF.md
# Four-Channel Low-Side Switch Diagnostic Controller

This block holds the digital control and diagnosis logic of a four-channel protected low-side power switch. Each channel has an active-high control input. All channels share an active-high enable input and an active-high standby input. The analog front end reports its comparator results as per-channel digital flags:
- load current under the open-load limit while the channel is on,
- drain voltage under the open-load level while the channel is off,
- a mismatch in the off-state comparison against the paired channel,
- overcurrent,
- overtemperature,
- the end of the paired channel's inductive flyback.

From these inputs the block produces three outputs per channel: the gate-drive enable, a pull-low request for the open-drain status pin, and the connect signal for the off-state pull-down resistor.

In normal operation the status pin reports the commanded switching state. Any detected fault inverts it. Overcurrent and overtemperature stay latched and keep the channel off until its control input is dropped. The result of the pair comparison is also latched, so that a flyback transient on the partner channel does not cause a false diagnosis. All inputs pass through two-flop synchronizers. Status changes that follow a gate switch are held back by a programmable number of cycles, which models the on and off status delays of the power stage.

Top module: `lss_diag_ctrl`

## Requirements
- R1: While rst_ni is low, every gate enable, status pull-low request and pull-down connect output is 0.
- R2: With standby low, every gate enable is 0, every status pull-low request is 0 (pin reads high) and every pull-down connect is 1'b0. Any stored overload, overtemperature or comparison fault is cleared. With standby high, pull-down connect is 1 on every channel.
- R3: A gate enable is 1 only when standby, enable and that channel's control input are all 1 and the channel has no stored overload or overtemperature fault. A change on an input reaches the gate enable at the third rising clock edge after it is applied.
- R4: The status level is the inverse of st_pull_o[k] (1 means the pin is pulled low, so the status reads low). With no fault present, the status level equals the channel's commanded state, enable AND control input.
- R5: When any fault is present on a channel, its status level is the inverse of the fault-free value for the same enable and control input.
- R6: The undercurrent flag is a fault only while the channel is commanded on. The low-voltage flag is ignored while the channel is commanded on.
- R7: The low-voltage flag is a fault only while the channel is commanded off. The undercurrent flag is ignored while the channel is commanded off.
- R8: Overcurrent or overtemperature seen while a channel is commanded on stores a fault and forces that gate off in the same cycle the flag is seen. The same flags seen while the channel is commanded off store nothing.
- R9: A stored overload or overtemperature fault is cleared only when that channel's control input is low. Dropping enable does not clear it, and the status reads high during a stored fault with enable low.
- R10: A pair-comparison mismatch seen while the channel's control input is low and enable is high sets a comparison latch, which counts as a fault and stays set after the flag drops. Channel k is paired with channel N_CH-1-k, so channel 0 pairs with 3 and channel 1 with 2.
- R11: The comparison latch of channel k is cleared by the flyback-end flag of its partner channel, by enable low, or by the channel's control input high.
- R12: When a gate enable changes, the status level holds its previous value. With an input change applied before clock edge 1, a status change caused by a gate switch appears at edge 4+ON_DLY for a switch on and edge 4+OFF_DLY for a switch off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stby_i | input | 1 | Standby control, low puts the block in standby |
| ena_i | input | 1 | Shared enable for all channels |
| in_i | input | N_CH | Per-channel control inputs |
| ucur_i | input | N_CH | On-state load current below open-load limit |
| ovlow_i | input | N_CH | Off-state drain voltage below open-load level |
| pmis_i | input | N_CH | Off-state pair comparison mismatch |
| ocur_i | input | N_CH | Overcurrent flag |
| otmp_i | input | N_CH | Overtemperature flag |
| fbend_i | input | N_CH | End of flyback on this channel |
| gate_en_o | output | N_CH | Gate-drive enable |
| st_pull_o | output | N_CH | Status pin pull-low request |
| pd_conn_o | output | N_CH | Off-state pull-down resistor connect |

## Verification
A vector table sweeps all four combinations of enable and control input, with and without standby. This separates the plain AND gating from the standby override. Each fault flag is applied in both the on and the off commanded state, which shows whether every flag is used only in the state where it is meaningful. Latch sequences then set a fault, remove the flag and change one clearing input at a time, such as enable low against control input low, or the partner flyback end against another channel's flyback end. These sequences show that each clear path works and that nothing else clears the latch. Directed edge-counted tests measure the synchronizer latency and the separate on and off status hold windows.

// File: rtl/lss_pkg.sv
package lss_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned FLAGS_PER_CH    = 7;  // in, ucur, ovlow, pmis, ocur, otmp, fbend

  function automatic int unsigned partner_of(input int unsigned k, input int unsigned n);
    return n - 1 - k;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lss_sync.sv
module lss_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lss_stat_dly.sv
module lss_stat_dly #(
  parameter int unsigned ON_DLY  = 3,
  parameter int unsigned OFF_DLY = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stby_i,
  input  logic gate_d_i,
  input  logic st_raw_i,
  output logic gate_o,
  output logic st_o
);
  localparam int unsigned DMAX  = lss_pkg::max_u(ON_DLY, OFF_DLY);
  localparam int unsigned CNT_W = (DMAX < 1) ? 1 : $clog2(DMAX + 1);
  localparam logic [CNT_W-1:0] ON_LD  = CNT_W'(ON_DLY);
  localparam logic [CNT_W-1:0] OFF_LD = CNT_W'(OFF_DLY);

  logic             gate_q;
  logic             st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      st_q   <= 1'b1;
      cnt_q  <= '0;
    end else if (!stby_i) begin
      gate_q <= 1'b0;
      st_q   <= 1'b1;
      cnt_q  <= '0;
    end else begin
      gate_q <= gate_d_i;
      if (gate_d_i != gate_q) begin
        cnt_q <= gate_d_i ? ON_LD : OFF_LD;  // status held on the switching edge
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end else begin
        st_q <= st_raw_i;
      end
    end
  end

  assign gate_o = gate_q;
  assign st_o   = st_q;
endmodule

// File: rtl/lss_chan.sv
module lss_chan #(
  parameter int unsigned ON_DLY  = 3,
  parameter int unsigned OFF_DLY = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stby_i,
  input  logic ena_i,
  input  logic in_i,
  input  logic ucur_i,
  input  logic ovlow_i,
  input  logic pmis_i,
  input  logic ocur_i,
  input  logic otmp_i,
  input  logic fbend_pair_i,
  output logic gate_o,
  output logic st_pull_o,
  output logic pd_o
);
  logic cmd;
  logic prot_q;
  logic cmp_q;
  logic pd_q;
  logic ol_flt;
  logic fault;
  logic gate_d;
  logic st_raw;
  logic st_lvl;

  assign cmd = ena_i & in_i;

  // overload / overtemperature store; control input low has priority
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         prot_q <= 1'b0;
    else if (!stby_i || !in_i)           prot_q <= 1'b0;
    else if (cmd && (ocur_i || otmp_i))  prot_q <= 1'b1;
  end

  // off-state pair comparison store; clear terms win over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cmp_q <= 1'b0;
    else if (!stby_i)                           cmp_q <= 1'b0;
    else if (fbend_pair_i || !ena_i || in_i)    cmp_q <= 1'b0;
    else if (pmis_i)                            cmp_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pd_q <= 1'b0;
    else         pd_q <= stby_i;
  end

  assign ol_flt = cmd ? ucur_i : (ovlow_i | cmp_q);
  assign fault  = prot_q | ol_flt;
  assign st_raw = cmd ^ fault;
  assign gate_d = stby_i & cmd & ~prot_q & ~ocur_i & ~otmp_i;

  lss_stat_dly #(
    .ON_DLY (ON_DLY),
    .OFF_DLY(OFF_DLY)
  ) u_dly (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stby_i  (stby_i),
    .gate_d_i(gate_d),
    .st_raw_i(st_raw),
    .gate_o  (gate_o),
    .st_o    (st_lvl)
  );

  assign st_pull_o = ~st_lvl;
  assign pd_o      = pd_q;
endmodule

// File: rtl/lss_diag_ctrl.sv
module lss_diag_ctrl #(
  parameter int unsigned N_CH        = 4,
  parameter int unsigned ON_DLY      = 3,
  parameter int unsigned OFF_DLY     = 5,
  parameter int unsigned SYNC_STAGES = lss_pkg::SYNC_STAGES_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stby_i,
  input  logic            ena_i,
  input  logic [N_CH-1:0] in_i,
  input  logic [N_CH-1:0] ucur_i,
  input  logic [N_CH-1:0] ovlow_i,
  input  logic [N_CH-1:0] pmis_i,
  input  logic [N_CH-1:0] ocur_i,
  input  logic [N_CH-1:0] otmp_i,
  input  logic [N_CH-1:0] fbend_i,
  output logic [N_CH-1:0] gate_en_o,
  output logic [N_CH-1:0] st_pull_o,
  output logic [N_CH-1:0] pd_conn_o
);
  localparam int unsigned SW = 2 + lss_pkg::FLAGS_PER_CH * N_CH;

  logic [SW-1:0]   raw_bus;
  logic [SW-1:0]   syn_bus;
  logic            s_stby;
  logic            s_ena;
  logic [N_CH-1:0] s_in;
  logic [N_CH-1:0] s_ucur;
  logic [N_CH-1:0] s_ovlow;
  logic [N_CH-1:0] s_pmis;
  logic [N_CH-1:0] s_ocur;
  logic [N_CH-1:0] s_otmp;
  logic [N_CH-1:0] s_fbend;

  assign raw_bus = {stby_i, ena_i, in_i, ucur_i, ovlow_i, pmis_i, ocur_i, otmp_i, fbend_i};

  lss_sync #(
    .W     (SW),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_bus),
    .q_o   (syn_bus)
  );

  assign {s_stby, s_ena, s_in, s_ucur, s_ovlow, s_pmis, s_ocur, s_otmp, s_fbend} = syn_bus;

  for (genvar k = 0; k < int'(N_CH); k++) begin : g_ch
    localparam int unsigned PK = lss_pkg::partner_of(k, N_CH);

    lss_chan #(
      .ON_DLY (ON_DLY),
      .OFF_DLY(OFF_DLY)
    ) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .stby_i      (s_stby),
      .ena_i       (s_ena),
      .in_i        (s_in[k]),
      .ucur_i      (s_ucur[k]),
      .ovlow_i     (s_ovlow[k]),
      .pmis_i      (s_pmis[k]),
      .ocur_i      (s_ocur[k]),
      .otmp_i      (s_otmp[k]),
      .fbend_pair_i(s_fbend[PK]),
      .gate_o      (gate_en_o[k]),
      .st_pull_o   (st_pull_o[k]),
      .pd_o        (pd_conn_o[k])
    );
  end
endmodule

// File: rtl/lss_diag_ctrl_chk.sv
module lss_diag_ctrl_chk #(
  parameter int unsigned N_CH = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            s_stby,
  input logic            s_ena,
  input logic [N_CH-1:0] s_in,
  input logic [N_CH-1:0] s_ocur,
  input logic [N_CH-1:0] s_otmp,
  input logic [N_CH-1:0] gate_en_o,
  input logic [N_CH-1:0] st_pull_o,
  input logic [N_CH-1:0] pd_conn_o
);
  AST_STBY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_stby |=> (gate_en_o == '0 && st_pull_o == '0 && pd_conn_o == '0)); // R2

  AST_GATE_NEEDS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_en_o & ~$past({N_CH{s_ena}} & s_in)) == '0); // R3

  AST_PROT_KILLS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_en_o & $past(gate_en_o & (s_ocur | s_otmp))) == '0); // R8

  AST_STATUS_HOLD_ON_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(s_stby) |-> (((gate_en_o ^ $past(gate_en_o)) & (st_pull_o ^ $past(st_pull_o))) == '0)); // R12
endmodule

bind lss_diag_ctrl lss_diag_ctrl_chk #(.N_CH(N_CH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .s_stby   (s_stby),
  .s_ena    (s_ena),
  .s_in     (s_in),
  .s_ocur   (s_ocur),
  .s_otmp   (s_otmp),
  .gate_en_o(gate_en_o),
  .st_pull_o(st_pull_o),
  .pd_conn_o(pd_conn_o)
);

// File: tb/lss_diag_ctrl_test.sv
`timescale 1ns/1ps
module lss_diag_ctrl_test;
  localparam int unsigned N  = 4;
  localparam int unsigned OND = 3;
  localparam int unsigned OFD = 5;
  localparam int NV = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic stby, ena;
  logic [N-1:0] in_v, uc, ovl, mis, oc, ot, fe;
  logic [N-1:0] gate, pull, pd;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lss_diag_ctrl #(.N_CH(N), .ON_DLY(OND), .OFF_DLY(OFD), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .stby_i(stby), .ena_i(ena), .in_i(in_v),
    .ucur_i(uc), .ovlow_i(ovl), .pmis_i(mis), .ocur_i(oc), .otmp_i(ot), .fbend_i(fe),
    .gate_en_o(gate), .st_pull_o(pull), .pd_conn_o(pd)
  );

  // stby, ena, in, ucur, ovlow, pmis, ocur, otmp, fbend | gate, status level
  localparam logic [37:0] VECS [NV] = '{
    {1'b0,1'b1,4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'hF},
    {1'b1,1'b0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0},
    {1'b1,1'b1,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0},
    {1'b1,1'b0,4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0},
    {1'b1,1'b1,4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'hF,4'hF},
    {1'b1,1'b1,4'h5,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h5,4'h5},
    {1'b1,1'b1,4'hF,4'h2,4'h0,4'h0,4'h0,4'h0,4'h0,4'hF,4'hD},
    {1'b1,1'b1,4'h0,4'h0,4'h4,4'h0,4'h0,4'h0,4'h0,4'h0,4'h4},
    {1'b1,1'b1,4'hF,4'h0,4'hF,4'h0,4'h0,4'h0,4'h0,4'hF,4'hF},
    {1'b1,1'b1,4'hF,4'h0,4'h0,4'h0,4'h1,4'h0,4'h0,4'hE,4'hE},
    {1'b1,1'b0,4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h1},
    {1'b1,1'b1,4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'hE,4'hE},
    {1'b1,1'b1,4'hE,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'hE,4'hE},
    {1'b1,1'b1,4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'hF,4'hF},
    {1'b1,1'b1,4'hF,4'h0,4'h0,4'h0,4'h0,4'h8,4'h0,4'h7,4'h7},
    {1'b1,1'b1,4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h7,4'h7},
    {1'b0,1'b1,4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'hF},
    {1'b1,1'b1,4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'hF,4'hF},
    {1'b1,1'b1,4'h0,4'h0,4'h0,4'h1,4'h0,4'h0,4'h0,4'h0,4'h1},
    {1'b1,1'b1,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h1},
    {1'b1,1'b1,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h2,4'h0,4'h1},
    {1'b1,1'b1,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h8,4'h0,4'h0},
    {1'b1,1'b1,4'h0,4'h0,4'h0,4'h2,4'h0,4'h0,4'h0,4'h0,4'h2},
    {1'b1,1'b0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0},
    {1'b1,1'b1,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0},
    {1'b1,1'b1,4'h0,4'h0,4'h0,4'h4,4'h0,4'h0,4'h0,4'h0,4'h4},
    {1'b1,1'b1,4'h4,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h4,4'h4},
    {1'b1,1'b1,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0},
    {1'b1,1'b1,4'hF,4'h0,4'h0,4'hF,4'h0,4'h0,4'h0,4'hF,4'hF},
    {1'b1,1'b1,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0},
    {1'b1,1'b1,4'h0,4'h0,4'h0,4'h0,4'hF,4'h0,4'h0,4'h0,4'h0},
    {1'b1,1'b1,4'hF,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'hF,4'hF}
  };

  function automatic string vec_tag(input int i);
    if (i == 0 || i == 16 || i == 17) return "R2";
    if (i <= 5)                       return "R3 R4";
    if (i == 6 || i == 8)             return "R5 R6";
    if (i == 7)                       return "R5 R7";
    if (i == 9 || i == 14 || i >= 30) return "R8";
    if (i <= 15)                      return "R9";
    if (i == 20 || i == 21 || i == 23 || i == 24 || i == 26 || i == 27) return "R11";
    return "R10";
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [37:0] v);
    stby = v[37]; ena = v[36]; in_v = v[35:32]; uc = v[31:28]; ovl = v[27:24];
    mis = v[23:20]; oc = v[19:16]; ot = v[15:12]; fe = v[11:8];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    put('0);
    tick(3);
    // R1: reset state
    chk("R1 gate", gate, 4'h0);
    chk("R1 pull", pull, 4'h0);
    chk("R1 pd", pd, 4'h0);
    rst_ni = 1'b1;
    tick(2);

    for (int i = 0; i < NV; i++) begin
      put(VECS[i]);
      tick(30);
      chk(vec_tag(i), gate, VECS[i][7:4]);
      chk(vec_tag(i), ~pull, VECS[i][3:0]);
      chk("R2 pd", pd, VECS[i][37] ? 4'hF : 4'h0);
    end

    // R3 / R12: latency and status hold windows on channel 0
    put({1'b1,1'b1,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,8'h00});
    tick(30);
    in_v = 4'h1;
    tick(2);
    chk("R3 gate before edge 3", gate, 4'h0);
    tick(1);
    chk("R3 gate at edge 3", gate, 4'h1);
    tick(OND + 3 - 3);
    chk("R12 status held before edge 4+ON_DLY", pull, 4'hF);
    tick(1);
    chk("R12 status at edge 4+ON_DLY", pull, 4'hE);
    in_v = 4'h0;
    tick(3);
    chk("R3 gate off at edge 3", gate, 4'h0);
    tick(OFD + 3 - 3);
    chk("R12 status held before edge 4+OFF_DLY", pull, 4'hE);
    tick(1);
    chk("R12 status at edge 4+OFF_DLY", pull, 4'hF);

    // R8: overcurrent on an on channel drops its gate at edge 3
    in_v = 4'hF;
    tick(30);
    oc = 4'h2;
    tick(3);
    chk("R8 gate drops with flag", gate, 4'hD);
    tick(30);
    chk("R8 stored status", ~pull, 4'hD);

    // R1: reset mid-run clears stored fault
    rst_ni = 1'b0;
    oc = 4'h0;
    tick(2);
    chk("R1 gate in reset", gate, 4'h0);
    chk("R1 pull in reset", pull, 4'h0);
    rst_ni = 1'b1;
    tick(30);
    chk("R1 fault cleared by reset", gate, 4'hF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule